// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Intervals

This block decides, once per second, whether a programmed alarm should raise an interrupt. A separate timekeeping block supplies the current second, minute, hour and day-of-month in BCD, along with a strobe that is high for one clock cycle each second. Four alarm registers hold the target time in BCD. They are written and read through a byte-wide register port.

Bit 7 of every alarm register is a mask flag. A masked field takes no part in the comparison. The pattern of mask flags sets the repeat interval: monthly, daily, hourly, every minute or every second. When the alarm fires, the block drives a single-cycle pulse on its interrupt output in the cycle after the strobe.

Top module: `alarm_match`

## Requirements
- R1: While reset is held (synchronous, active low), all four alarm registers clear to 0x00 and `irq` is low. Both remain in that state in the first cycle after reset.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours and 3 date. `rdata` returns the full stored byte of the addressed register, mask bit 7 included, combinationally.
- R3: A write to seconds or minutes is stored only when bits 6:0, decoded as tens in 6:4 and units in 3:0 (value = tens*10 + units), give a value of 59 or less. Any other write leaves the register unchanged.
- R4: A write to hours is stored only when bits 5:0, decoded as tens*10 + units, give 23 or less. A write to date is stored only when bits 5:0 are not all zero.
- R5: `irq` is high for exactly one cycle, the cycle after a cycle where `sec_tick` is high and the alarm matches. Without `sec_tick`, `irq` stays low.
- R6: With all four mask bits clear, a match requires equal date (5:0), hour (5:0), minute (6:0) and second (6:0).
- R7: With only the date mask set, a match requires equal hour, minute and second.
- R8: With the date and hour masks set and the others clear, a match requires equal minute and second.
- R9: With the date, hour and minute masks set and the seconds mask clear, a match requires equal second.
- R10: Every other mask pattern, including any pattern with the seconds mask set, matches on every `sec_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| sec_tick | input | 1 | One-cycle strobe each second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The in-line assertions check four properties on every cycle:
- the interrupt appears only after a strobe;
- a seconds write whose tens digit is out of range leaves the register unchanged;
- a well-formed hours write is stored;
- any pattern with the seconds mask set fires on every strobe.

The choice among the monthly, daily, hourly and minutely modes, the date and minute write limits, readback of the mask bits, and the reset values can only be shown by the bench. The bench drives each mask pattern with both matching and deliberately mismatched time fields, and compares `irq` on every clock against a behavioural model.

// File: rtl/alarm_match.sv
module alarm_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sec_tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  output logic       irq
);

  logic [7:0] a_sec, a_min, a_hour, a_date;
  logic       ok_sec, ok_hour, ok_date, hit;
  logic       eq_s, eq_m, eq_h, eq_d;

  function automatic logic [6:0] bcd_val(input logic [6:0] v);
    return 7'(v[6:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  assign ok_sec  = bcd_val(wdata[6:0]) <= 7'd59;
  assign ok_hour = bcd_val({1'b0, wdata[5:0]}) <= 7'd23;
  assign ok_date = |wdata[5:0];

  assign eq_s = a_sec[6:0]  == now_sec[6:0];
  assign eq_m = a_min[6:0]  == now_min[6:0];
  assign eq_h = a_hour[5:0] == now_hour[5:0];
  assign eq_d = a_date[5:0] == now_date[5:0];

  always_comb begin
    case ({a_date[7], a_hour[7], a_min[7], a_sec[7]})
      4'b0000: hit = eq_d & eq_h & eq_m & eq_s;
      4'b1000: hit = eq_h & eq_m & eq_s;
      4'b1100: hit = eq_m & eq_s;
      4'b1110: hit = eq_s;
      default: hit = 1'b1;
    endcase
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = a_sec;
      2'd1:    rdata = a_min;
      2'd2:    rdata = a_hour;
      default: rdata = a_date;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec  <= 8'h00;
      a_min  <= 8'h00;
      a_hour <= 8'h00;
      a_date <= 8'h00;
      irq    <= 1'b0;
    end else begin
      irq <= sec_tick & hit;
      if (we) begin
        case (addr)
          2'd0:    if (ok_sec)  a_sec  <= wdata;
          2'd1:    if (ok_sec)  a_min  <= wdata;
          2'd2:    if (ok_hour) a_hour <= wdata;
          default: if (ok_date) a_date <= wdata;
        endcase
      end
    end
  end

  assert_irq_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sec_tick));

  assert_sec_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0 && wdata[6:4] > 3'd5) |=> $stable(a_sec));

  assert_hour_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd2 && wdata[5:4] < 2'd2 && wdata[3:0] < 4'd10)
      |=> a_hour == $past(wdata));

  assert_every_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && a_sec[7] && !(we && addr == 2'd0)) |=> irq);

endmodule

// File: tb/alarm_match_tb.sv
module alarm_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sec_tick = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h01;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int m_reg [4];
  bit exp_irq = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_date(now_date), .irq(irq)
  );

  function automatic int dec(input int b);
    return ((b >> 4) & 7) * 10 + (b & 15);
  endfunction

  function automatic bit model_match();
    bit ms, mm, mh, md;
    bit s, m, h, d;
    ms = m_reg[0][7]; mm = m_reg[1][7]; mh = m_reg[2][7]; md = m_reg[3][7];
    s = dec(m_reg[0] & 8'h7f) == dec(now_sec & 8'h7f);
    m = dec(m_reg[1] & 8'h7f) == dec(now_min & 8'h7f);
    h = dec(m_reg[2] & 8'h3f) == dec(now_hour & 8'h3f);
    d = dec(m_reg[3] & 8'h3f) == dec(now_date & 8'h3f);
    if (ms) return 1'b1;
    if (!md && !mh && !mm) return d && h && m && s;
    if (md && !mh && !mm) return h && m && s;
    if (md && mh && !mm) return m && s;
    if (md && mh && mm) return s;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
      exp_irq = 1'b0;
    end else begin
      exp_irq = sec_tick && model_match();
      if (we) begin
        case (addr)
          2'd0, 2'd1: if (dec(wdata & 8'h7f) <= 59) m_reg[addr] = wdata;
          2'd2:       if (dec(wdata & 8'h3f) <= 23) m_reg[2] = wdata;
          default:    if ((wdata & 8'h3f) != 0) m_reg[3] = wdata;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) chk("R5 irq vs model", irq, exp_irq);

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tick(input logic [7:0] d, input logic [7:0] h, input logic [7:0] m,
                      input logic [7:0] s, input bit exp, input string tag);
    @(negedge clk);
    now_date = d; now_hour = h; now_min = m; now_sec = s; sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk(tag, irq, exp);
    @(negedge clk);
    chk({tag, " pulse ends"}, irq, 0);
  endtask

  task automatic set_alarm(input logic [7:0] d, input logic [7:0] h,
                           input logic [7:0] m, input logic [7:0] s);
    wr(2'd3, d); wr(2'd2, h); wr(2'd1, m); wr(2'd0, s);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd(i[1:0], 8'h00, "R1 reset value");

    // R2 readback including mask bit
    wr(2'd0, 8'hB7); rd(2'd0, 8'hB7, "R2 sec readback");
    wr(2'd1, 8'h42); rd(2'd1, 8'h42, "R2 min readback");
    // R3 range checks
    wr(2'd0, 8'h60); rd(2'd0, 8'hB7, "R3 sec 60 rejected");
    wr(2'd0, 8'h5A); rd(2'd0, 8'hB7, "R3 sec 5A rejected");
    wr(2'd0, 8'h59); rd(2'd0, 8'h59, "R3 sec 59 accepted");
    wr(2'd1, 8'h7F); rd(2'd1, 8'h42, "R3 min 7F rejected");
    // R4
    wr(2'd2, 8'h24); rd(2'd2, 8'h00, "R4 hour 24 rejected");
    wr(2'd2, 8'hA3); rd(2'd2, 8'hA3, "R4 hour 23 masked accepted");
    wr(2'd3, 8'h00); rd(2'd3, 8'h00, "R4 date 00 rejected");
    wr(2'd3, 8'hC0); rd(2'd3, 8'h00, "R4 date C0 rejected");
    wr(2'd3, 8'h31); rd(2'd3, 8'h31, "R4 date 31 accepted");

    // R6 monthly
    set_alarm(8'h15, 8'h10, 8'h20, 8'h30);
    tick(8'h15, 8'h10, 8'h20, 8'h30, 1, "R6 full match");
    tick(8'h16, 8'h10, 8'h20, 8'h30, 0, "R6 date differs");
    tick(8'h15, 8'h10, 8'h20, 8'h31, 0, "R6 sec differs");
    // R5 matching time without tick
    @(negedge clk); now_date = 8'h15; now_sec = 8'h30;
    repeat (3) @(negedge clk);
    chk("R5 no tick no irq", irq, 0);

    // R7 daily
    set_alarm(8'h95, 8'h10, 8'h20, 8'h30);
    tick(8'h02, 8'h10, 8'h20, 8'h30, 1, "R7 other date fires");
    tick(8'h02, 8'h11, 8'h20, 8'h30, 0, "R7 hour differs");
    // R8 hourly
    set_alarm(8'h95, 8'h90, 8'h20, 8'h30);
    tick(8'h07, 8'h05, 8'h20, 8'h30, 1, "R8 other hour fires");
    tick(8'h07, 8'h05, 8'h21, 8'h30, 0, "R8 minute differs");
    // R9 minutely
    set_alarm(8'h95, 8'h90, 8'hA0, 8'h30);
    tick(8'h07, 8'h05, 8'h44, 8'h30, 1, "R9 other minute fires");
    tick(8'h07, 8'h05, 8'h44, 8'h29, 0, "R9 second differs");
    // R10 every second: seconds mask set, and a gapped pattern
    set_alarm(8'h15, 8'h10, 8'h20, 8'hB0);
    tick(8'h01, 8'h00, 8'h00, 8'h01, 1, "R10 sec mask fires");
    set_alarm(8'h15, 8'h90, 8'h20, 8'h30);
    tick(8'h01, 8'h00, 8'h00, 8'h01, 1, "R10 hour-only mask fires");
    set_alarm(8'h95, 8'h10, 8'hA0, 8'h30);
    tick(8'h01, 8'h00, 8'h00, 8'h02, 1, "R10 date+min mask fires");

    // R1 reset clears again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, 8'h00, "R1 sec after reset");
    rd(2'd3, 8'h00, "R1 date after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule